// File: doc/BRIEF.md
# PLL Acquisition and Lock Monitor

This block is the digital control and status logic that sits beside a clock PLL's loop filter. An external frequency comparator reports how far the VCO is from its target as an unsigned error magnitude, qualified by a valid strobe. In automatic mode the block uses two separate hysteresis windows on that magnitude. The first window produces the filter-mode bit, where 1 means tracking and 0 means acquisition. The second window produces the lock status bit. Each time the lock status changes, the block can latch an interrupt request.

In manual mode the filter-mode bit becomes a plain software-written control bit. Lock status and interrupts are held off in this mode. While the PLL is switched off, every output is held at 0. Because of this, the filter is always in acquisition when the PLL starts.

The error input is a valid-qualified stream with no back-pressure. The block has no ready signal because it consumes every sample that carries `err_valid` in that same cycle. A cycle without `err_valid` is ignored. Control pins are plain levels. The register bus is reduced to a write strobe for the filter-mode bit and a write-one acknowledge for the interrupt.

Top module: `pll_lock_monitor`

## Requirements
- R1: After a synchronous active-low reset, `acq_o`, `lock_o` and `irq_o` are all 0.
- R2: With `pll_on`=1 and `auto_mode`=1, a valid error not greater than TRK_THR sets `acq_o` on the next clock edge.
- R3: In automatic mode, a valid error greater than UNT_THR clears `acq_o`. A valid error strictly between the two thresholds leaves it unchanged, and so does any cycle with `err_valid`=0.
- R4: In automatic mode, `lock_o` is set by a valid error not greater than LCK_THR and cleared by a valid error greater than UNL_THR. A valid error in between, or a cycle with no valid error, leaves it unchanged.
- R5: In automatic mode with `irq_en`=1, every change of `lock_o` in either direction sets `irq_o` in the same clock edge. With `irq_en`=0 no change sets it.
- R6: `irq_o` stays set until a cycle with `irq_ack`=1 clears it. If a lock change happens in the same cycle as the acknowledge, `irq_o` stays 1.
- R7: With `pll_on`=1 and `auto_mode`=0, a cycle with `acq_wr_en`=1 loads `acq_wr_data` into `acq_o`. Otherwise `acq_o` holds its value, and the error stream has no effect on it.
- R8: In manual mode `lock_o` and `irq_o` are 0 one cycle after `auto_mode` is 0.
- R9: A cycle with `pll_on`=0 clears all three outputs on the next edge and ignores `acq_wr_en`. Turning the PLL off never raises `irq_o`.
- R10: Any change of `auto_mode` while `pll_on`=1 clears `acq_o` and `lock_o` on that edge without raising `irq_o`. Evaluation resumes from 0 after that edge.
- R11: All outputs are registered. Each output reflects the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_on | input | 1 | PLL enabled |
| auto_mode | input | 1 | 1 = automatic bandwidth control, 0 = manual |
| irq_en | input | 1 | Enables the lock-change interrupt |
| acq_wr_en | input | 1 | Write strobe for the manual filter-mode bit |
| acq_wr_data | input | 1 | Value written to the filter-mode bit |
| irq_ack | input | 1 | Write-one-to-clear for the interrupt request |
| err_valid | input | 1 | Error sample valid; no ready, always accepted |
| err_mag | input | ERR_W | Unsigned VCO frequency error magnitude |
| acq_o | output | 1 | Filter mode: 1 tracking, 0 acquisition |
| lock_o | output | 1 | Lock status |
| irq_o | output | 1 | Sticky lock-change interrupt request |

## Verification
The bench sweeps every error value with a ramp that runs downward and then back up. This ramp separates a correct hysteresis window from a single threshold, and it separates inclusive comparisons from exclusive ones at each of the four bounds. A pseudo-random order of magnitudes with gaps in the valid strobe and occasional acknowledges then checks four things:
- that samples without the strobe are skipped;
- that lock changes in both directions are latched;
- that an acknowledge loses against a coincident toggle;
- that `irq_en`=0 suppresses interrupts.

Manual-mode write patterns with a live error stream show that the error stream cannot move ACQ in manual mode. Mode switches and power-off cycles placed while lock is set show that those clears produce no interrupt.

// File: rtl/pllmon_pkg.sv
package pllmon_pkg;
  typedef enum logic [1:0] {
    HYS_HOLD = 2'd0,
    HYS_SET  = 2'd1,
    HYS_CLR  = 2'd2
  } hys_act_e;

  // Decide the action of one hysteresis window for one valid sample.
  function automatic hys_act_e hys_classify(input int unsigned mag,
                                            input int unsigned set_thr,
                                            input int unsigned clr_thr);
    if (mag <= set_thr)      return HYS_SET;
    else if (mag > clr_thr)  return HYS_CLR;
    else                     return HYS_HOLD;
  endfunction
endpackage

// File: rtl/pllmon_hyst_window.sv
module pllmon_hyst_window
  import pllmon_pkg::*;
#(
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned SET_THR = 8,
  parameter int unsigned CLR_THR = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic             ld_val,
  input  logic             eval_en,
  input  logic             s_valid,
  input  logic [ERR_W-1:0] s_mag,
  output logic             flag_q,
  output logic             change
);
  hys_act_e act;
  logic     nxt;
  logic     sampling;

  always_comb begin
    act      = hys_classify(32'(s_mag), SET_THR, CLR_THR);
    sampling = eval_en && s_valid && !clr && !ld;
    unique case (act)
      HYS_SET: nxt = 1'b1;
      HYS_CLR: nxt = 1'b0;
      default: nxt = flag_q;
    endcase
    change = sampling && (nxt != flag_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (clr)               flag_q <= 1'b0;
    else if (ld)                flag_q <= ld_val;
    else if (eval_en && s_valid) flag_q <= nxt;
  end
endmodule

// File: rtl/pllmon_irq_flag.sv
module pllmon_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set,
  input  logic ack,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (kill)  irq_q <= 1'b0;
    else if (set)   irq_q <= 1'b1;
    else if (ack)   irq_q <= 1'b0;
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned TRK_THR = 8,
  parameter int unsigned UNT_THR = 24,
  parameter int unsigned LCK_THR = 4,
  parameter int unsigned UNL_THR = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_on,
  input  logic             auto_mode,
  input  logic             irq_en,
  input  logic             acq_wr_en,
  input  logic             acq_wr_data,
  input  logic             irq_ack,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_mag,
  output logic             acq_o,
  output logic             lock_o,
  output logic             irq_o
);
  logic auto_prev_q;
  logic mode_flip;
  logic run_auto;
  logic acq_clr, acq_ld;
  logic lock_clr;
  logic acq_chg, lock_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) auto_prev_q <= 1'b0;
    else        auto_prev_q <= auto_mode;
  end

  always_comb begin
    mode_flip = auto_mode != auto_prev_q;
    run_auto  = pll_on && auto_mode && !mode_flip;
    acq_clr   = !pll_on || mode_flip;
    acq_ld    = pll_on && !auto_mode && acq_wr_en;
    lock_clr  = !pll_on || !auto_mode || mode_flip;
  end

  // Filter-mode window: tracking/untracking thresholds, software load in manual mode.
  pllmon_hyst_window #(
    .ERR_W(ERR_W), .SET_THR(TRK_THR), .CLR_THR(UNT_THR)
  ) u_acq_win (
    .clk(clk), .rst_n(rst_n), .clr(acq_clr), .ld(acq_ld), .ld_val(acq_wr_data),
    .eval_en(run_auto), .s_valid(err_valid), .s_mag(err_mag),
    .flag_q(acq_o), .change(acq_chg)
  );

  // Lock window: lock/unlock thresholds, no software load.
  pllmon_hyst_window #(
    .ERR_W(ERR_W), .SET_THR(LCK_THR), .CLR_THR(UNL_THR)
  ) u_lock_win (
    .clk(clk), .rst_n(rst_n), .clr(lock_clr), .ld(1'b0), .ld_val(1'b0),
    .eval_en(run_auto), .s_valid(err_valid), .s_mag(err_mag),
    .flag_q(lock_o), .change(lock_chg)
  );

  pllmon_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n),
    .kill(!pll_on || !auto_mode),
    .set(lock_chg && irq_en),
    .ack(irq_ack),
    .irq_q(irq_o)
  );

  logic unused_acq_chg;
  assign unused_acq_chg = acq_chg;
endmodule

// File: rtl/pllmon_checker.sv
module pllmon_checker #(
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned TRK_THR = 8,
  parameter int unsigned UNT_THR = 24,
  parameter int unsigned LCK_THR = 4,
  parameter int unsigned UNL_THR = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pll_on,
  input logic             auto_mode,
  input logic             irq_en,
  input logic             acq_wr_en,
  input logic             err_valid,
  input logic [ERR_W-1:0] err_mag,
  input logic             acq_o,
  input logic             lock_o,
  input logic             irq_o
);
  a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |=> (!acq_o && !lock_o && !irq_o));

  a_r8_manual_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> (!lock_o && !irq_o));

  a_r4_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(err_valid && (32'(err_mag) <= LCK_THR)));

  a_r4_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(!pll_on || !auto_mode || (err_valid && (32'(err_mag) > UNL_THR))));

  a_r2_acq_rise_auto: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acq_o) && $past(auto_mode)) |-> $past(err_valid && (32'(err_mag) <= TRK_THR)));

  a_r5_irq_needs_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((lock_o != $past(lock_o)) && $past(irq_en)));

  a_r7_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_on && !auto_mode && $past(pll_on && !auto_mode) && !acq_wr_en) |=> $stable(acq_o));
endmodule

bind pll_lock_monitor pllmon_checker #(
  .ERR_W(ERR_W), .TRK_THR(TRK_THR), .UNT_THR(UNT_THR),
  .LCK_THR(LCK_THR), .UNL_THR(UNL_THR)
) u_pllmon_chk (
  .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .auto_mode(auto_mode),
  .irq_en(irq_en), .acq_wr_en(acq_wr_en), .err_valid(err_valid),
  .err_mag(err_mag), .acq_o(acq_o), .lock_o(lock_o), .irq_o(irq_o)
);

// File: tb/pll_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module pll_lock_monitor_tb_top;
  localparam int W = 8, TRK = 8, UNT = 24, LCK = 4, UNL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll_on = 1'b0, auto_mode = 1'b0, irq_en = 1'b0;
  logic acq_wr_en = 1'b0, acq_wr_data = 1'b0, irq_ack = 1'b0, err_valid = 1'b0;
  logic [W-1:0] err_mag = '0;
  logic acq_o, lock_o, irq_o;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // Bench model state
  bit m_acq = 0, m_lock = 0, m_irq = 0, m_prev_auto = 0;

  always #4 clk = ~clk;

  pll_lock_monitor #(.ERR_W(W), .TRK_THR(TRK), .UNT_THR(UNT), .LCK_THR(LCK), .UNL_THR(UNL))
  dut_i (.clk(clk), .rst_n(rst_n), .pll_on(pll_on), .auto_mode(auto_mode), .irq_en(irq_en),
         .acq_wr_en(acq_wr_en), .acq_wr_data(acq_wr_data), .irq_ack(irq_ack),
         .err_valid(err_valid), .err_mag(err_mag), .acq_o(acq_o), .lock_o(lock_o), .irq_o(irq_o));

  function automatic bit win(bit cur, int mag, int lo, int hi);
    if (mag <= lo) return 1'b1;
    if (mag > hi)  return 1'b0;
    return cur;
  endfunction

  task automatic check(string req);
    n_vec++;
    if ({acq_o, lock_o, irq_o} !== {m_acq, m_lock, m_irq}) begin
      n_bad++;
      $display("FAIL %s: acq/lock/irq actual %b%b%b expected %b%b%b (mag=%0d v=%b)",
               req, acq_o, lock_o, irq_o, m_acq, m_lock, m_irq, err_mag, err_valid);
    end
  endtask

  // Drive one cycle at negedge, update model, compare at following negedge (R11 latency).
  task automatic step(bit on, bit au, bit ie, bit we, bit wd, bit v, int mag, bit ack, string req);
    bit nl;
    pll_on = on; auto_mode = au; irq_en = ie; acq_wr_en = we; acq_wr_data = wd;
    err_valid = v; err_mag = W'(mag); irq_ack = ack;
    if (!on) begin
      m_acq = 0; m_lock = 0; m_irq = 0;                       // R9
    end else if (au != m_prev_auto) begin
      m_acq = 0; m_lock = 0; m_irq = 0;                       // R10
    end else if (au) begin
      if (v) begin
        m_acq = win(m_acq, mag, TRK, UNT);                    // R2 R3
        nl = win(m_lock, mag, LCK, UNL);                      // R4
        if (nl != m_lock && ie) m_irq = 1;                    // R5 R6
        else if (ack) m_irq = 0;
        m_lock = nl;
      end else if (ack) m_irq = 0;
    end else begin
      if (we) m_acq = wd;                                     // R7
      m_lock = 0; m_irq = 0;                                  // R8
    end
    m_prev_auto = au;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_vec++;
    if ({acq_o, lock_o, irq_o} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1: actual %b%b%b expected 000", acq_o, lock_o, irq_o);
    end
    step(1, 1, 1, 0, 0, 0, 0, 0, "R10");
    // Ramp down then up: hysteresis and inclusive/exclusive bounds (R2 R3 R4 R5)
    for (int i = 255; i >= 0; i--) step(1, 1, 1, 0, 0, 1, i, 1, "R2_R4_R5");
    for (int i = 0; i < 256; i++)  step(1, 1, 1, 0, 0, 1, i, 0, "R3_R4_R5");
    // Scrambled order, valid gaps, occasional ack coincident with toggles (R3 R6)
    for (int i = 0; i < 768; i++)
      step(1, 1, 1, 0, 0, (i % 5) != 0, ((i * 37 + 5) % 32), (i % 7) == 3, "R3_R6");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 0, 0, 0, 1, "R6");
    // irq_en low: toggles must not raise irq (R5)
    for (int i = 0; i < 256; i++)
      step(1, 1, 0, 0, 0, 1, (i * 11) % 40, 0, "R5");
    // Lock held, then switch to manual: clears lock, no irq (R10 R8)
    step(1, 1, 0, 0, 0, 1, 0, 0, "R4");
    step(1, 0, 1, 0, 0, 1, 0, 0, "R10");
    for (int i = 0; i < 128; i++)
      step(1, 0, 1, (i % 3) == 0, (i % 6) == 0, 1, i % 30, 0, "R7_R8");
    // Back to automatic restarts from 0 (R10)
    step(1, 1, 1, 0, 0, 1, 0, 0, "R10");
    step(1, 1, 1, 0, 0, 1, 0, 0, "R4_R5");
    // Power off with lock set: no irq, writes ignored (R9)
    for (int i = 0; i < 8; i++) step(0, 1, 1, 1, 1, 1, 0, 0, "R9");
    step(1, 0, 1, 0, 0, 0, 0, 0, "R10");
    step(1, 0, 1, 1, 1, 0, 0, 0, "R7");
    step(0, 0, 1, 1, 1, 0, 0, 0, "R9");
    step(1, 0, 1, 0, 0, 1, 0, 0, "R9_R7");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule